// File: doc/BRIEF.md
# Express Queue Admission Controller

This block sits at a hub router beside one long-distance express link. It holds up to six flits waiting for that link and decides, as each candidate flit arrives, whether the flit may join the queue. The decision comes from a 2-bit congestion level that follows the queue occupancy with hysteresis. The level climbs at once when the queue fills, but falls one step at a time as the queue drains. At low occupancy every flit is taken. At middle occupancy a flit is taken with a probability of one half or one fifth, using a free-running pseudo-random register. At full occupancy every flit is turned away.

A rejected arrival gets a one-cycle drop pulse in the cycle it is offered, so the router can clear the flit's express marking and send it on the ordinary mesh path. The first cycle the level reads congested produces a one-cycle back-pressure request toward the neighbouring routers. The link side pulls flits in arrival order with a valid/ready pair.

Top module: `xq_admit`

## Requirements
- R1: The queue holds at most DEPTH (6) flits and hands them to the link in arrival order. `link_valid` is high whenever the queue is non-empty, and `link_flit` shows the oldest flit. A flit leaves on a clock edge where `link_valid` and `link_ready` are both high.
- R2: In a cycle with `arr_valid` high, exactly one of `arr_take` and `arr_drop` is high, combinationally in that same cycle; with `arr_valid` low both are low. The verdict follows the action code: TAKE always admits, DROP never admits, HALF admits when rnd < 512, and FIFTH admits when rnd < 205. Here rnd is bits [9:0] of the random register. A queue whose seen occupancy is 6 rejects whatever the action.
- R3: The seen occupancy is the stored count minus one if a flit leaves in the same cycle. The action is looked up with the current level and the seen occupancy. The post occupancy is the seen occupancy plus one if the arrival is admitted.
- R4: On an event (an arrival or a departure), the next level is looked up with the current level and the post occupancy. Levels are 0 calm, 1 warm, 2 hot and 3 jammed, and n is the occupancy used for the lookup.
  - From level 0: n 0..1 gives level 0, action TAKE; n 2..3 gives level 1, TAKE; n 4..5 gives level 2, HALF; n 6 gives level 3, DROP.
  - From level 1: n < 2 gives level 0, TAKE; n 2..3 gives level 1, TAKE; n > 3 gives level 2, HALF.
  - From level 2: n < 4 gives level 1, HALF; n 4..5 gives level 2, FIFTH; n 6 gives level 3, DROP.
  - From level 3: n < 6 gives level 2, FIFTH; n 6 gives level 3, DROP.
- R5: Reset puts the level at 0 and empties the queue. In a cycle with no arrival and no departure, the level holds.
- R6: `bp_req` is high for exactly the one cycle in which `level` first reads 3 after having read something else.
- R7: The random register is 16 bits wide and resets to 0xACE1. Every clock it shifts toward the MSB, and bit 15 XOR bit 13 XOR bit 12 XOR bit 10 enters at bit 0.
- R8: The level never falls by more than one step: from level 3 the next level is 2 or 3, and from level 2 the next level is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_valid | input | 1 | An express candidate flit is offered this cycle |
| arr_flit | input | W | Offered flit |
| arr_take | output | 1 | Offered flit admitted to the queue |
| arr_drop | output | 1 | Offered flit refused; route it on the mesh |
| link_valid | output | 1 | Queue holds a flit for the link |
| link_flit | output | W | Oldest queued flit |
| link_ready | input | 1 | Link accepts the flit this cycle |
| level | output | 2 | Congestion level (0 calm .. 3 jammed) |
| bp_req | output | 1 | One-cycle back-pressure request on entry to level 3 |

## Verification
The two functions that can fall in one cycle are an arrival verdict and a departure to the link, and they interact through the seen occupancy. The bench provokes this by holding `link_ready` high while offering flits on a non-empty queue, including the full queue, where a departure turns a certain reject into a decided one. A behavioural model keeps its own queue, level and random register. Each cycle it predicts the verdict, the level, the back-pressure pulse and the head flit from the rules above, and compares them against the outputs.

// File: rtl/xq_pkg.sv
package xq_pkg;
  typedef enum logic [1:0] {
    LV_CALM = 2'd0,
    LV_WARM = 2'd1,
    LV_HOT  = 2'd2,
    LV_JAM  = 2'd3
  } lvl_t;

  typedef enum logic [1:0] {
    ACT_TAKE  = 2'd0,
    ACT_DROP  = 2'd1,
    ACT_HALF  = 2'd2,
    ACT_FIFTH = 2'd3
  } act_t;
endpackage

// File: rtl/xq_lfsr.sv
module xq_lfsr #(
  parameter int          RW    = 16,
  parameter logic [RW-1:0] SEED  = 16'hACE1,
  parameter logic [RW-1:0] TAPS  = 16'hB400,
  parameter int          OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [RW-1:0] r_q, r_d;
  logic          fb;

  always_comb begin
    fb  = ^(r_q & TAPS);
    r_d = {r_q[RW-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= SEED;
    else        r_q <= r_d;
  end

  assign rnd = r_q[OUT_W-1:0];
endmodule

// File: rtl/xq_fifo.sv
module xq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 6,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout = mem[rd_q];
  assign cnt  = cnt_q;
endmodule

// File: rtl/xq_fsm.sv
module xq_fsm
  import xq_pkg::*;
#(
  parameter int DEPTH     = 6,
  parameter int LOW_MARK  = 2,
  parameter int HIGH_MARK = 4,
  parameter int RND_W     = 10,
  parameter int HALF_LIM  = 512,
  parameter int FIFTH_LIM = 205,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arr_valid,
  input  logic             pop,
  input  logic [CW-1:0]    cnt,
  input  logic [RND_W-1:0] rnd,
  output logic             admit,
  output logic [1:0]       level,
  output logic             bp_req
);
  localparam logic [CW-1:0]    LOW  = CW'(LOW_MARK);
  localparam logic [CW-1:0]    HIGH = CW'(HIGH_MARK);
  localparam logic [CW-1:0]    FULL = CW'(DEPTH);
  localparam logic [RND_W-1:0] HL   = RND_W'(HALF_LIM);
  localparam logic [RND_W-1:0] FL   = RND_W'(FIFTH_LIM);

  function automatic act_t act_of(lvl_t s, logic [CW-1:0] n);
    case (s)
      LV_CALM: act_of = (n < HIGH) ? ACT_TAKE : (n < FULL) ? ACT_HALF : ACT_DROP;
      LV_WARM: act_of = (n < HIGH) ? ACT_TAKE : ACT_HALF;
      LV_HOT:  act_of = (n < HIGH) ? ACT_HALF : (n < FULL) ? ACT_FIFTH : ACT_DROP;
      default: act_of = (n < FULL) ? ACT_FIFTH : ACT_DROP;
    endcase
  endfunction

  function automatic lvl_t next_of(lvl_t s, logic [CW-1:0] n);
    case (s)
      LV_CALM: next_of = (n < LOW) ? LV_CALM : (n < HIGH) ? LV_WARM :
                         (n < FULL) ? LV_HOT : LV_JAM;
      LV_WARM: next_of = (n < LOW) ? LV_CALM : (n < HIGH) ? LV_WARM : LV_HOT;
      LV_HOT:  next_of = (n < HIGH) ? LV_WARM : (n < FULL) ? LV_HOT : LV_JAM;
      default: next_of = (n < FULL) ? LV_HOT : LV_JAM;
    endcase
  endfunction

  lvl_t          lvl_q, lvl_d;
  logic          bp_q, bp_d;
  logic [CW-1:0] seen, post;
  act_t          act;
  logic          lucky, full, event_now;

  always_comb begin
    seen = cnt - {{(CW-1){1'b0}}, pop};
    act  = act_of(lvl_q, seen);
    full = (seen >= FULL);
    case (act)
      ACT_TAKE:  lucky = 1'b1;
      ACT_HALF:  lucky = (rnd < HL);
      ACT_FIFTH: lucky = (rnd < FL);
      default:   lucky = 1'b0;
    endcase
    admit     = arr_valid && !full && lucky;
    post      = seen + {{(CW-1){1'b0}}, admit};
    event_now = arr_valid || pop;
    lvl_d     = event_now ? next_of(lvl_q, post) : lvl_q;
    bp_d      = (lvl_d == LV_JAM) && (lvl_q != LV_JAM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LV_CALM;
      bp_q  <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      bp_q  <= bp_d;
    end
  end

  assign level  = lvl_q;
  assign bp_req = bp_q;
endmodule

// File: rtl/xq_admit.sv
module xq_admit #(
  parameter int W         = 32,
  parameter int DEPTH     = 6,
  parameter int LOW_MARK  = 2,
  parameter int HIGH_MARK = 4,
  parameter int RND_W     = 10,
  parameter int HALF_LIM  = 512,
  parameter int FIFTH_LIM = 205,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arr_valid,
  input  logic [W-1:0] arr_flit,
  output logic         arr_take,
  output logic         arr_drop,
  output logic         link_valid,
  output logic [W-1:0] link_flit,
  input  logic         link_ready,
  output logic [1:0]   level,
  output logic         bp_req
);
  logic [CW-1:0]    occ;
  logic [RND_W-1:0] rnd;
  logic             admit, pop;

  assign link_valid = (occ != '0);
  assign pop        = link_valid && link_ready;
  assign arr_take   = admit;
  assign arr_drop   = arr_valid && !admit;

  xq_lfsr #(.RW(16), .SEED(16'hACE1), .TAPS(16'hB400), .OUT_W(RND_W)) u_rng (
    .clk (clk),
    .rst_n (rst_n),
    .rnd (rnd)
  );

  xq_fifo #(.W(W), .DEPTH(DEPTH)) u_q (
    .clk  (clk),
    .rst_n (rst_n),
    .push (admit),
    .din  (arr_flit),
    .pop  (pop),
    .dout (link_flit),
    .cnt  (occ)
  );

  xq_fsm #(
    .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK),
    .RND_W(RND_W), .HALF_LIM(HALF_LIM), .FIFTH_LIM(FIFTH_LIM)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .arr_valid (arr_valid),
    .pop       (pop),
    .cnt       (occ),
    .rnd       (rnd),
    .admit     (admit),
    .level     (level),
    .bp_req    (bp_req)
  );
endmodule

// File: rtl/xq_admit_chk.sv
module xq_admit_chk #(
  parameter int DEPTH = 6,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arr_valid,
  input logic          arr_take,
  input logic          arr_drop,
  input logic          link_valid,
  input logic          link_ready,
  input logic [1:0]    level,
  input logic          bp_req,
  input logic [CW-1:0] occ
);
  logic leave;
  assign leave = link_valid && link_ready;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH)); // R1
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |-> (arr_take ^ arr_drop)); // R2
  AST_NO_IDLE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_valid |-> (!arr_take && !arr_drop)); // R2
  AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && occ == CW'(DEPTH) && !leave) |-> arr_drop); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!arr_valid && !leave) |=> $stable(level)); // R5
  AST_BP_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |-> (level == 2'd3 && $past(level) != 2'd3)); // R6
  AST_ENTRY_GIVES_BP: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 2'd3 && $past(level) != 2'd3) |-> bp_req); // R6
  AST_JAM_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    level == 2'd3 |=> level[1]); // R8
  AST_HOT_NOT_CALM: assert property (@(posedge clk) disable iff (!rst_n)
    level == 2'd2 |=> level != 2'd0); // R8
endmodule

bind xq_admit xq_admit_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arr_valid  (arr_valid),
  .arr_take   (arr_take),
  .arr_drop   (arr_drop),
  .link_valid (link_valid),
  .link_ready (link_ready),
  .level      (level),
  .bp_req     (bp_req),
  .occ        (occ)
);

// File: tb/xq_admit_test.sv
module xq_admit_test;
  logic        clk;
  logic        rst_n;
  logic        arr_valid;
  logic [31:0] arr_flit;
  logic        arr_take, arr_drop, link_valid, link_ready, bp_req;
  logic [31:0] link_flit;
  logic [1:0]  level;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_q[$];
  int          m_lvl;
  bit          m_bp;
  logic [15:0] m_rng;
  int          seed_lcg = 12345;

  xq_admit uut (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_flit(arr_flit),
    .arr_take(arr_take), .arr_drop(arr_drop), .link_valid(link_valid),
    .link_flit(link_flit), .link_ready(link_ready), .level(level), .bp_req(bp_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // actions: 0 take, 1 drop, 2 half, 3 fifth
  function automatic int act_for(int s, int n);
    case (s)
      0: return (n <= 3) ? 0 : (n <= 5) ? 2 : 1;
      1: return (n <= 3) ? 0 : 2;
      2: return (n <= 3) ? 2 : (n <= 5) ? 3 : 1;
      default: return (n <= 5) ? 3 : 1;
    endcase
  endfunction

  function automatic int lvl_for(int s, int n);
    case (s)
      0: return (n <= 1) ? 0 : (n <= 3) ? 1 : (n <= 5) ? 2 : 3;
      1: return (n <= 1) ? 0 : (n <= 3) ? 1 : 2;
      2: return (n <= 3) ? 1 : (n <= 5) ? 2 : 3;
      default: return (n <= 5) ? 2 : 3;
    endcase
  endfunction

  // called just after a falling edge
  task automatic step(bit v, logic [31:0] d, bit rdy);
    int  cnt, seen, a, nl;
    bit  pop, ok;
    logic [9:0] r;
    arr_valid  = v;
    arr_flit   = d;
    link_ready = rdy;
    #2;
    cnt = m_q.size();
    chk("R4 level", {30'd0, level}, m_lvl[31:0]);
    chk("R6 bp_req", {31'd0, bp_req}, {31'd0, m_bp});
    chk("R1 link_valid", {31'd0, link_valid}, {31'd0, cnt > 0});
    if (cnt > 0) chk("R1 link_flit", link_flit, m_q[0]);
    pop  = (cnt > 0) && rdy;
    seen = cnt - (pop ? 1 : 0);
    a    = act_for(m_lvl, seen);
    r    = m_rng[9:0];
    ok   = (seen < 6) && ((a == 0) || (a == 2 && r < 10'd512) || (a == 3 && r < 10'd205));
    if (v) begin
      chk("R2/R3/R7 take", {31'd0, arr_take}, {31'd0, ok});
      chk("R2/R3/R7 drop", {31'd0, arr_drop}, {31'd0, !ok});
    end else begin
      chk("R2 idle take", {31'd0, arr_take}, 32'd0);
      chk("R2 idle drop", {31'd0, arr_drop}, 32'd0);
    end
    if (pop) void'(m_q.pop_front());
    if (v && ok) m_q.push_back(d);
    nl    = (v || pop) ? lvl_for(m_lvl, m_q.size()) : m_lvl;
    m_bp  = (nl == 3) && (m_lvl != 3);
    m_lvl = nl;
    m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
    @(negedge clk);
  endtask

  function automatic int next_rand();
    seed_lcg = seed_lcg * 1103515245 + 12345;
    return (seed_lcg >>> 8) & 32'h7fff;
  endfunction

  initial begin
    int k;
    rst_n = 1'b0;
    arr_valid = 1'b0;
    arr_flit = '0;
    link_ready = 1'b0;
    m_lvl = 0;
    m_bp = 0;
    m_rng = 16'hACE1;
    repeat (3) @(negedge clk);
    // R5: reset state
    chk("R5 reset level", {30'd0, level}, 32'd0);
    chk("R5 reset link_valid", {31'd0, link_valid}, 32'd0);
    chk("R6 reset bp_req", {31'd0, bp_req}, 32'd0);
    rst_n = 1'b1;
    k = 0;
    // fill with link stalled: fast rise, probabilistic admission, full rejects
    for (int i = 0; i < 60; i++) begin step(1'b1, 32'h1000 + i, 1'b0); end
    // R5: idle holds level
    for (int i = 0; i < 5; i++) begin step(1'b0, '0, 1'b0); end
    // R3: arrival on a full queue with a departure in the same cycle
    for (int i = 0; i < 30; i++) begin step(1'b1, 32'h2000 + i, 1'b1); end
    // R8: drain, slow fall
    for (int i = 0; i < 10; i++) begin step(1'b0, '0, 1'b1); end
    // refill then mixed traffic
    for (int i = 0; i < 40; i++) begin step(1'b1, 32'h3000 + i, 1'b0); end
    for (int i = 0; i < 3000; i++) begin
      k = next_rand();
      step(k[0] | k[1], 32'h4000_0000 + i, (k[4:2] < 3'd3));
    end
    for (int i = 0; i < 12; i++) begin step(1'b0, '0, 1'b1); end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired R1 got=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule